// File: doc/BRIEF.md
# Sync Period Meter

The block times display sync signals that arrive already split into a horizontal and a vertical line. For the vertical line it counts strobes of a 125 kHz enable between two consecutive leading edges of the sync pulse. The result is a 13-bit frame period that software converts with f = 125000 / (count + 1). For the horizontal line it counts system clock cycles, with the system clock running at 6 MHz, between two consecutive leading edges. The result is an 8-bit line period, and f = 6 MHz / (count + 1).

Each input passes through a synchronizer. An edge detector then compares how long the line stays high with how long it stays low and treats the shorter phase as the pulse, which gives the polarity. The leading edge of that pulse is the one that closes a measurement. Results are latched once per interval, so reads between captures always see a whole value. A small select input picks one of three result bytes, and the byte is returned at once.

Top module: `sync_period_meter`

## Requirements
- R1: After reset the vertical low byte and the horizontal byte read 0x00. The vertical high byte reads 0x40 while the vertical input is low (level 0, polarity positive, no overflow, count 0).
- R2: The vertical count latched at a leading edge equals the number of cycles with the 125 kHz strobe high strictly between that edge and the previous leading edge. The first leading edge after reset only starts timing and latches nothing.
- R3: If more than 8191 strobes fall inside one vertical interval, the counter holds at 8191 and the latched result reads count 8191 with the overflow flag set. The next interval that fits restarts from zero and latches with the flag clear.
- R4: Select 0 returns the vertical count bits 7..0. Select 1 returns level (bit 7), polarity (bit 6), overflow (bit 5) and count bits 12..8 (bits 4..0). Select 2 returns the horizontal count. Select 3 returns 0x00.
- R5: The level bit follows the vertical input with two clock cycles of delay: unchanged after one rising clock edge, updated after the second.
- R6: The polarity bit reads 1 when the last measured high phase is no longer than the last measured low phase, and 0 otherwise. The leading edge is the rising edge for positive polarity and the falling edge for negative polarity.
- R7: The horizontal byte latched at a leading edge equals the number of clock cycles between consecutive leading edges minus one, for intervals of 2 to 256 cycles.
- R8: A horizontal interval longer than 256 cycles latches as 0x00.
- R9: Latched values do not change between leading edges, whatever the strobe does.
- R10: The vertical counter advances only in cycles where the 125 kHz strobe is high. The horizontal counter ignores the strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (6 MHz in the target use) |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_125k | input | 1 | One-cycle 125 kHz enable for the vertical counter |
| hsync_in | input | 1 | Separated horizontal sync, asynchronous |
| vsync_in | input | 1 | Separated vertical sync, asynchronous |
| rd_sel | input | 2 | Result byte select |
| rd_data | output | 8 | Selected result byte, combinational from the select |

## Verification
A leading edge on a sync input closes its measurement at the third rising clock edge after the input changes: two synchronizer stages, then the edge flag, then the latch. The level bit moves at the second rising edge. The bench drives inputs on falling edges and ends every run of frames with four idle cycles at the inactive level before it reads. Each value is therefore sampled after the last capture and before any further one. The R5 check reads one and two edges after the change, so the exact delay is pinned down. Expected counts come from frame length and tick placement: period minus one, the width of a tick window, or saturation.

// File: rtl/smu_pkg.sv
package smu_pkg;

  typedef enum logic [1:0] {
    SEL_VLO  = 2'd0,
    SEL_VHI  = 2'd1,
    SEL_HPER = 2'd2,
    SEL_NONE = 2'd3
  } rd_sel_e;

  // Polarity rule: the shorter phase is the pulse; a tie counts as positive.
  function automatic logic pulse_is_high(input logic [31:0] hi_len,
                                         input logic [31:0] lo_len);
    return hi_len <= lo_len;
  endfunction

  // Vertical status byte: level, polarity, overflow, count bits 12..8.
  function automatic logic [7:0] vert_hi_byte(input logic lvl, input logic pol,
                                              input logic ovf,
                                              input logic [15:0] cnt);
    return {lvl, pol, ovf, cnt[12:8]};
  endfunction

  // Saturating increment used for the phase-length runs.
  function automatic logic [31:0] sat_inc(input logic [31:0] v,
                                          input logic [31:0] vmax);
    return (v >= vmax) ? vmax : v + 32'd1;
  endfunction

endpackage

// File: rtl/smu_sync_edge.sv
module smu_sync_edge #(
  parameter int STAGES  = 2,
  parameter int PHASE_W = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic level,
  output logic lead_edge,
  output logic pos_pol
);
  localparam logic [31:0] PH_MAX = 32'((64'd1 << PHASE_W) - 1);

  logic [STAGES-1:0]  sh;
  logic               lvl_d;
  logic [PHASE_W-1:0] hi_run, lo_run, hi_len, lo_len;
  logic               rise, fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh    <= '0;
      lvl_d <= 1'b0;
    end else begin
      sh    <= {sh[STAGES-2:0], pin};
      lvl_d <= sh[STAGES-1];
    end
  end

  assign level = sh[STAGES-1];
  assign rise  = level & ~lvl_d;
  assign fall  = ~level & lvl_d;

  // Phase length measurement for polarity decision.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_run <= '0;
      lo_run <= '0;
      hi_len <= '0;
      lo_len <= '0;
    end else if (rise) begin
      lo_len <= lo_run;
      hi_run <= PHASE_W'(1);
    end else if (fall) begin
      hi_len <= hi_run;
      lo_run <= PHASE_W'(1);
    end else if (level) begin
      hi_run <= PHASE_W'(smu_pkg::sat_inc(32'(hi_run), PH_MAX));
    end else begin
      lo_run <= PHASE_W'(smu_pkg::sat_inc(32'(lo_run), PH_MAX));
    end
  end

  assign pos_pol   = smu_pkg::pulse_is_high(32'(hi_len), 32'(lo_len));
  assign lead_edge = pos_pol ? rise : fall;

  // R6: polarity only moves when the line changes level
  a_r6_pol_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise || fall) |=> $stable(pos_pol));

  // R6: a leading edge leaves the line at the pulse level
  a_r6_edge_level: assert property (@(posedge clk) disable iff (!rst_n)
    lead_edge |-> (pos_pol ? level : !level));

endmodule

// File: rtl/smu_period_ctr.sv
module smu_period_ctr #(
  parameter int CNT_W       = 13,
  parameter bit ZERO_ON_OVF = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             edge_i,
  output logic [CNT_W-1:0] cap_cnt,
  output logic             cap_ovf
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] run_cnt, report_val;
  logic             run_ovf, armed;
  logic             at_max, step, capture;

  assign at_max  = (run_cnt == CNT_MAX);
  assign step    = adv && !edge_i;
  assign capture = edge_i && armed;

  generate
    if (ZERO_ON_OVF) begin : g_zero
      assign report_val = run_ovf ? '0 : run_cnt;
    end else begin : g_sat
      assign report_val = run_cnt;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt <= '0;
      run_ovf <= 1'b0;
      armed   <= 1'b0;
      cap_cnt <= '0;
      cap_ovf <= 1'b0;
    end else if (edge_i) begin
      run_cnt <= '0;
      run_ovf <= 1'b0;
      armed   <= 1'b1;
      if (armed) begin
        cap_cnt <= report_val;
        cap_ovf <= run_ovf;
      end
    end else if (step) begin
      if (at_max) run_ovf <= 1'b1;
      else        run_cnt <= run_cnt + 1'b1;
    end
  end

  // R2: every leading edge restarts timing from zero
  a_r2_restart: assert property (@(posedge clk) disable iff (!rst_n)
    edge_i |=> (run_cnt == '0) && !run_ovf);

  // R3: once overflowed the counter sits at its ceiling until an edge
  a_r3_sat_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (run_ovf && !edge_i) |=> run_ovf && (run_cnt == CNT_MAX));

  // R3 / R8: an overflowed interval latches the flag and the chosen report value
  a_r3_r8_ovf_report: assert property (@(posedge clk) disable iff (!rst_n)
    (capture && run_ovf) |=> cap_ovf && (cap_cnt == (ZERO_ON_OVF ? '0 : CNT_MAX)));

  // R9: latched result holds between captures
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> $stable(cap_cnt) && $stable(cap_ovf));

  // R10: no advance without the enable
  a_r10_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !edge_i) |=> $stable(run_cnt));

endmodule

// File: rtl/sync_period_meter.sv
module sync_period_meter #(
  parameter int V_W         = 13,
  parameter int H_W         = 8,
  parameter int SYNC_STAGES = 2,
  parameter int PHASE_W     = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_125k,
  input  logic       hsync_in,
  input  logic       vsync_in,
  input  logic [1:0] rd_sel,
  output logic [7:0] rd_data
);
  import smu_pkg::*;

  logic           v_lvl, v_edge, v_pol, v_ovf;
  logic           h_lvl, h_edge, h_pol, h_ovf;
  logic [V_W-1:0] v_cap;
  logic [H_W-1:0] h_cap;

  smu_sync_edge #(.STAGES(SYNC_STAGES), .PHASE_W(PHASE_W)) u_v_edge (
    .clk(clk), .rst_n(rst_n), .pin(vsync_in),
    .level(v_lvl), .lead_edge(v_edge), .pos_pol(v_pol));

  smu_sync_edge #(.STAGES(SYNC_STAGES), .PHASE_W(PHASE_W)) u_h_edge (
    .clk(clk), .rst_n(rst_n), .pin(hsync_in),
    .level(h_lvl), .lead_edge(h_edge), .pos_pol(h_pol));

  smu_period_ctr #(.CNT_W(V_W), .ZERO_ON_OVF(1'b0)) u_v_ctr (
    .clk(clk), .rst_n(rst_n), .adv(tick_125k), .edge_i(v_edge),
    .cap_cnt(v_cap), .cap_ovf(v_ovf));

  smu_period_ctr #(.CNT_W(H_W), .ZERO_ON_OVF(1'b1)) u_h_ctr (
    .clk(clk), .rst_n(rst_n), .adv(1'b1), .edge_i(h_edge),
    .cap_cnt(h_cap), .cap_ovf(h_ovf));

  always_comb begin
    case (rd_sel_e'(rd_sel))
      SEL_VLO:  rd_data = v_cap[7:0];
      SEL_VHI:  rd_data = vert_hi_byte(v_lvl, v_pol, v_ovf, 16'(v_cap));
      SEL_HPER: rd_data = 8'(h_cap);
      default:  rd_data = 8'h00;
    endcase
  end

  // R7: horizontal leading edge leaves the line at its pulse level
  a_r7_h_edge_level: assert property (@(posedge clk) disable iff (!rst_n)
    h_edge |-> (h_pol ? h_lvl : !h_lvl));

  // R8: an overflowed horizontal result always reads zero
  a_r8_h_zero: assert property (@(posedge clk) disable iff (!rst_n)
    h_ovf |-> (h_cap == '0));

  // R4: unused select always reads zero
  a_r4_sel_none: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sel == 2'd3) |-> (rd_data == 8'h00));

endmodule

// File: tb/tb_sync_period_meter.sv
module tb_sync_period_meter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_125k = 1'b0;
  logic       hsync_in = 1'b0;
  logic       vsync_in = 1'b0;
  logic [1:0] rd_sel = 2'd0;
  logic [7:0] rd_data;

  int  n_checks = 0;
  int  n_errors = 0;
  bit  done = 1'b0;

  sync_period_meter dut (
    .clk(clk), .rst_n(rst_n), .tick_125k(tick_125k), .hsync_in(hsync_in),
    .vsync_in(vsync_in), .rd_sel(rd_sel), .rd_data(rd_data));

  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_errors++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic rd(input logic [1:0] sel, output logic [7:0] val);
    rd_sel = sel;
    #1;
    val = rd_data;
  endtask

  function automatic logic [7:0] exp_hi(input bit lvl, input bit pol,
                                        input bit ovf, input int cnt);
    return {lvl, pol, ovf, 5'((cnt / 256) % 32)};
  endfunction

  // Vertical frames; tlo < 0 means strobe every cycle, else strobe in [tlo,thi).
  task automatic vrun(input int period, input int width, input bit pos,
                      input int nfr, input int tlo, input int thi);
    for (int f = 0; f < nfr; f++) begin
      for (int i = 0; i < period; i++) begin
        @(negedge clk);
        vsync_in  = pos ? (i < width) : !(i < width);
        tick_125k = (tlo < 0) ? 1'b1 : (i >= tlo && i < thi);
      end
    end
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      vsync_in  = !pos;
      tick_125k = 1'b0;
    end
    @(negedge clk);
  endtask

  task automatic hrun(input int period, input int nfr);
    for (int f = 0; f < nfr; f++) begin
      for (int i = 0; i < period; i++) begin
        @(negedge clk);
        hsync_in = (i == 0);
      end
    end
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      hsync_in = 1'b0;
    end
    @(negedge clk);
  endtask

  task automatic vcheck(input string req, input int cnt, input bit lvl,
                        input bit pol, input bit ovf);
    logic [7:0] lo, hi;
    rd(2'd0, lo);
    rd(2'd1, hi);
    chk({req, " vlo"}, lo, 8'(cnt % 256));
    chk({req, " vhi"}, hi, exp_hi(lvl, pol, ovf, cnt));
  endtask

  initial begin
    logic [7:0] v, lo0, hi0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state, R4 select map
    rd(2'd0, v); chk("R1 vlo", v, 8'h00);
    rd(2'd1, v); chk("R1 vhi", v, 8'h40);
    rd(2'd2, v); chk("R1 hper", v, 8'h00);
    rd(2'd3, v); chk("R4 sel3", v, 8'h00);

    // R5 level delay; R2 first edge arms only
    vsync_in = 1'b1;
    @(negedge clk); rd(2'd1, v); chk("R5 one edge", v, 8'h40);
    @(negedge clk); rd(2'd1, v); chk("R5 two edges", v, 8'hC0);
    repeat (3) @(negedge clk);
    rd(2'd0, v); chk("R2 arm lo", v, 8'h00);
    rd(2'd1, v); chk("R2 arm hi", v, 8'hC0);
    vsync_in = 1'b0;
    repeat (3) @(negedge clk);

    // R2 / R4 / R6 positive periods, strobe every cycle
    vrun(20, 4, 1'b1, 3, -1, 0);    vcheck("R2 p20", 19, 0, 1, 0);
    vrun(100, 4, 1'b1, 3, -1, 0);   vcheck("R2 p100", 99, 0, 1, 0);
    vrun(1000, 10, 1'b1, 3, -1, 0); vcheck("R4 p1000", 999, 0, 1, 0);
    vrun(8192, 10, 1'b1, 3, -1, 0); vcheck("R3 p8192 edge", 8191, 0, 1, 0);

    // R3 overflow then recovery
    vrun(8193, 10, 1'b1, 3, -1, 0); vcheck("R3 ovf", 8191, 0, 1, 1);
    vrun(500, 10, 1'b1, 1, -1, 0);  vcheck("R3 ovf latched", 8191, 0, 1, 1);
    vrun(500, 10, 1'b1, 2, -1, 0);  vcheck("R3 recover", 499, 0, 1, 0);

    // R9 hold between captures with the strobe running
    rd(2'd0, lo0); rd(2'd1, hi0);
    tick_125k = 1'b1;
    repeat (100) @(negedge clk);
    tick_125k = 1'b0;
    rd(2'd0, v); chk("R9 hold lo", v, lo0);
    rd(2'd1, v); chk("R9 hold hi", v, hi0);

    // R10 strobe gating: counts equal the strobe window
    vrun(1000, 10, 1'b1, 3, 100, 137); vcheck("R10 window37", 37, 0, 1, 0);
    vrun(1000, 10, 1'b1, 3, 100, 100); vcheck("R10 no strobe", 0, 0, 1, 0);

    // R6 negative polarity: falling edge leads, level idles high
    vrun(600, 10, 1'b0, 4, -1, 0);  vcheck("R6 negative", 599, 1, 0, 0);
    vrun(300, 10, 1'b1, 4, -1, 0);  vcheck("R6 back positive", 299, 0, 1, 0);

    // R7 near-exhaustive horizontal sweep, strobe held low (R10)
    for (int p = 2; p <= 64; p++) begin
      hrun(p, 3);
      rd(2'd2, v); chk($sformatf("R7 h p%0d", p), v, 8'(p - 1));
    end
    hrun(100, 3); rd(2'd2, v); chk("R7 h p100", v, 8'd99);
    hrun(255, 3); rd(2'd2, v); chk("R7 h p255", v, 8'd254);
    hrun(256, 3); rd(2'd2, v); chk("R7 h p256", v, 8'd255);
    hrun(257, 3); rd(2'd2, v); chk("R8 h p257", v, 8'd0);
    hrun(300, 3); rd(2'd2, v); chk("R8 h p300", v, 8'd0);
    hrun(40, 3);  rd(2'd2, v); chk("R8 h recover", v, 8'd39);
    rd(2'd1, v); chk("R9 v unchanged by h", v, hi0 & 8'h00 | exp_hi(0, 1, 0, 299));

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

endmodule